// File: doc/BRIEF.md
# Display Controller Miscellaneous Port Front End

This block sits on an 8-bit I/O bus with a 16-bit port address and separate read and write strobes, in front of a display controller. It holds an 8-bit control byte, the miscellaneous output register, and breaks it out into named control fields for the timing and clocking logic. Bit 0 of the byte picks the colour or monochrome base address. The block uses that bit to decode the CRT controller index and data ports and the input status port at one of two bases.

The block passes CRT controller accesses to the register file behind it as strobes, together with the write data. On a read it returns the byte that the register file supplies. A read of the status port reports the retrace flags from the timing generator and clears the attribute controller's index/data toggle with a single pulse. Read data is combinational and only valid while the read strobe is high. All register state updates on the clock edge where the write strobe is sampled.

Top module: `vga_misc_decoder`

## Requirements
- R1: While reset is held and after it is released, the control byte is 0x00. Every field output and `attr_ff_clr` is 0, and the monochrome base is in use.
- R2: A write to port 0x03C2 loads `io_wdata` into the control byte at that clock edge. A read of port 0x03CC returns the byte in the same cycle.
- R3: With bit 0 of the byte at 1 (colour), the CRT controller index and data ports are 0x03D4 and 0x03D5. In this mode 0x03B4 and 0x03B5 raise no strobe and read as 0xFF.
- R4: With bit 0 at 0 (mono), the CRT controller ports are 0x03B4 and 0x03B5. In this mode 0x03D4 and 0x03D5 raise no strobe and read as 0xFF.
- R5: The status port is 0x03DA in colour mode and 0x03BA in mono mode. The other address reads as 0xFF and has no side effect.
- R6: A status read returns bit 0 = vertical OR horizontal retrace and bit 3 = vertical retrace, with all other bits 0.
- R7: `attr_ff_clr` is high for exactly the one cycle after each cycle in which a decoded status read is present, and low otherwise.
- R8: The field outputs follow the byte: `color_mode` = bit 0, `clk_sel` = bits 3:2 (0 = 25 MHz, 1 = 28 MHz), `hi_bank` = bit 5, `hsync_neg` = bit 6, `vsync_neg` = bit 7, `line_code` = bits 7:6 (1 = 400, 2 = 350, 3 = 480 lines).
- R9: Reads of undecoded ports, including 0x03C2, return 0xFF. Any cycle without `io_rd` also reads 0xFF. Writes to undecoded ports, including 0x03CC, leave the byte unchanged.
- R10: A change of bit 0 moves the base starting with the bus access in the cycle right after the write.
- R11: A CRT controller access raises the matching strobe in the same cycle. Writes present `io_wdata` on `crtc_wdata`, and reads return `crtc_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O port address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data (0xFF when undecoded or idle) |
| vretrace | input | 1 | Vertical retrace active |
| hretrace | input | 1 | Horizontal retrace active |
| crtc_rdata | input | 8 | Read data from the CRT controller register file |
| crtc_idx_wr | output | 1 | CRT controller index port write strobe |
| crtc_dat_wr | output | 1 | CRT controller data port write strobe |
| crtc_idx_rd | output | 1 | CRT controller index port read strobe |
| crtc_dat_rd | output | 1 | CRT controller data port read strobe |
| crtc_wdata | output | 8 | Write data forwarded to the CRT controller |
| attr_ff_clr | output | 1 | One-cycle clear for the attribute index/data toggle |
| color_mode | output | 1 | Colour base selected |
| clk_sel | output | 2 | Pixel clock select |
| hi_bank | output | 1 | High 64 KiB bank in odd/even modes |
| hsync_neg | output | 1 | Negative horizontal sync polarity |
| vsync_neg | output | 1 | Negative vertical sync polarity |
| line_code | output | 2 | Display line count code |

## Verification
Read data and every CRT controller strobe are due in the same cycle as the access, so the bench samples them one nanosecond after it drives the inputs at the falling edge. Field outputs and the active base change one edge after a control write, and `attr_ff_clr` rises one edge after a status read. The bench's model therefore applies writes and read side effects only after the rising edge and compares them in the next cycle's sample. Base-change checks put the access in the cycle directly after the write, which catches any extra delay stage.

// File: rtl/vga_misc_pkg.sv
package vga_misc_pkg;

  localparam logic [15:0] MISC_WR_PORT = 16'h03C2;
  localparam logic [15:0] MISC_RD_PORT = 16'h03CC;
  localparam logic [15:0] MONO_BASE    = 16'h03B0;
  localparam logic [15:0] COLOR_BASE   = 16'h03D0;
  localparam logic [15:0] OFS_CIDX     = 16'h0004;
  localparam logic [15:0] OFS_CDAT     = 16'h0005;
  localparam logic [15:0] OFS_STAT     = 16'h000A;

  localparam int STAT_ANY_BIT = 0;
  localparam int STAT_VR_BIT  = 3;

  // bit order matches the control byte, MSB first
  typedef struct packed {
    logic       vsync_neg;
    logic       hsync_neg;
    logic       hi_bank;
    logic       spare4;
    logic [1:0] clk_sel;
    logic       spare1;
    logic       color;
  } misc_t;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MISC_W,
    SEL_MISC_R,
    SEL_CIDX,
    SEL_CDAT,
    SEL_STAT
  } port_sel_e;

endpackage

// File: rtl/vga_port_decode.sv
module vga_port_decode
  import vga_misc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              color,
  output port_sel_e         sel
);

  localparam logic [ADDR_W-1:0] A_MISC_W = ADDR_W'(MISC_WR_PORT);
  localparam logic [ADDR_W-1:0] A_MISC_R = ADDR_W'(MISC_RD_PORT);
  localparam logic [ADDR_W-1:0] A_MONO   = ADDR_W'(MONO_BASE);
  localparam logic [ADDR_W-1:0] A_COLOR  = ADDR_W'(COLOR_BASE);
  localparam logic [ADDR_W-1:0] A_CIDX   = ADDR_W'(OFS_CIDX);
  localparam logic [ADDR_W-1:0] A_CDAT   = ADDR_W'(OFS_CDAT);
  localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(OFS_STAT);

  logic [ADDR_W-1:0] base;

  always_comb begin
    base = color ? A_COLOR : A_MONO;
    sel  = SEL_NONE;
    if (io_addr == A_MISC_W)               sel = SEL_MISC_W;
    else if (io_addr == A_MISC_R)          sel = SEL_MISC_R;
    else if (io_addr == base + A_CIDX)     sel = SEL_CIDX;
    else if (io_addr == base + A_CDAT)     sel = SEL_CDAT;
    else if (io_addr == base + A_STAT)     sel = SEL_STAT;
  end

endmodule

// File: rtl/vga_misc_reg.sv
module vga_misc_reg
  import vga_misc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_en,
  input  logic [7:0] load_val,
  output misc_t      misc_q
);

  misc_t misc_d;

  always_comb begin
    misc_d = misc_q;
    if (load_en) misc_d = misc_t'(load_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       misc_q <= '0;
    else if (load_en) misc_q <= misc_d;
  end

  a_r2_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (8'(misc_q) == $past(load_val)));

  a_r9_hold_unless_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(misc_q));

endmodule

// File: rtl/vga_status_unit.sv
module vga_status_unit
  import vga_misc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stat_rd,
  input  logic       vretrace,
  input  logic       hretrace,
  output logic [7:0] stat_byte,
  output logic       attr_clr
);

  logic clr_d;

  always_comb begin
    stat_byte               = '0;
    stat_byte[STAT_ANY_BIT] = vretrace | hretrace;
    stat_byte[STAT_VR_BIT]  = vretrace;
    clr_d                   = stat_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) attr_clr <= 1'b0;
    else        attr_clr <= clr_d;
  end

  a_r6_vr_implies_any: assert property (@(posedge clk) disable iff (!rst_n)
    stat_byte[STAT_VR_BIT] |-> stat_byte[STAT_ANY_BIT]);

  a_r6_quiet_bits: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(stat_byte) <= 2);

endmodule

// File: rtl/vga_misc_decoder.sv
module vga_misc_decoder
  import vga_misc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic              vretrace,
  input  logic              hretrace,
  input  logic [7:0]        crtc_rdata,
  output logic              crtc_idx_wr,
  output logic              crtc_dat_wr,
  output logic              crtc_idx_rd,
  output logic              crtc_dat_rd,
  output logic [7:0]        crtc_wdata,
  output logic              attr_ff_clr,
  output logic              color_mode,
  output logic [1:0]        clk_sel,
  output logic              hi_bank,
  output logic              hsync_neg,
  output logic              vsync_neg,
  output logic [1:0]        line_code
);

  localparam logic [7:0] IDLE_BYTE = 8'hFF;

  misc_t      misc_q;
  port_sel_e  sel;
  logic [7:0] stat_byte;
  logic       misc_load;
  logic       stat_rd;

  vga_port_decode #(.ADDR_W(ADDR_W)) u_decode (
    .io_addr (io_addr),
    .color   (misc_q.color),
    .sel     (sel)
  );

  assign misc_load = io_wr && (sel == SEL_MISC_W);
  assign stat_rd   = io_rd && (sel == SEL_STAT);

  vga_misc_reg u_misc (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (misc_load),
    .load_val (io_wdata),
    .misc_q   (misc_q)
  );

  vga_status_unit u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .stat_rd   (stat_rd),
    .vretrace  (vretrace),
    .hretrace  (hretrace),
    .stat_byte (stat_byte),
    .attr_clr  (attr_ff_clr)
  );

  always_comb begin
    crtc_idx_wr = io_wr && (sel == SEL_CIDX);
    crtc_dat_wr = io_wr && (sel == SEL_CDAT);
    crtc_idx_rd = io_rd && (sel == SEL_CIDX);
    crtc_dat_rd = io_rd && (sel == SEL_CDAT);
    crtc_wdata  = io_wdata;
  end

  always_comb begin
    io_rdata = IDLE_BYTE;
    if (io_rd) begin
      unique case (sel)
        SEL_MISC_R: io_rdata = 8'(misc_q);
        SEL_CIDX,
        SEL_CDAT:   io_rdata = crtc_rdata;
        SEL_STAT:   io_rdata = stat_byte;
        default:    io_rdata = IDLE_BYTE;
      endcase
    end
  end

  always_comb begin
    color_mode = misc_q.color;
    clk_sel    = misc_q.clk_sel;
    hi_bank    = misc_q.hi_bank;
    hsync_neg  = misc_q.hsync_neg;
    vsync_neg  = misc_q.vsync_neg;
    line_code  = {misc_q.vsync_neg, misc_q.hsync_neg};
  end

  a_r8_clk_sel_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == ADDR_W'(MISC_WR_PORT)) |=> (clk_sel == $past(io_wdata[3:2])));

  a_r3_mono_ports_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && color_mode && io_addr == ADDR_W'(16'h03B4)) |-> (!crtc_idx_rd && io_rdata == 8'hFF));

  a_r4_color_ports_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !color_mode && io_addr == ADDR_W'(16'h03D5)) |-> !crtc_dat_wr);

  a_r10_base_moves_next: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == ADDR_W'(MISC_WR_PORT) && io_wdata[0])
      |=> (!(io_rd && io_addr == ADDR_W'(16'h03D4)) || crtc_idx_rd));

  a_r7_clr_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && color_mode && io_addr == ADDR_W'(16'h03DA)) |=> attr_ff_clr);

  a_r11_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({crtc_idx_wr, crtc_dat_wr}));

endmodule

// File: tb/test_vga_misc_decoder.sv
module test_vga_misc_decoder;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] io_addr;
  logic        io_wr, io_rd;
  logic [7:0]  io_wdata, io_rdata, crtc_rdata, crtc_wdata;
  logic        vretrace, hretrace;
  logic        crtc_idx_wr, crtc_dat_wr, crtc_idx_rd, crtc_dat_rd;
  logic        attr_ff_clr, color_mode, hi_bank, hsync_neg, vsync_neg;
  logic [1:0]  clk_sel, line_code;

  always #2 clk = ~clk;

  vga_misc_decoder i_vga_misc_decoder (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .vretrace(vretrace), .hretrace(hretrace),
    .crtc_rdata(crtc_rdata), .crtc_idx_wr(crtc_idx_wr), .crtc_dat_wr(crtc_dat_wr),
    .crtc_idx_rd(crtc_idx_rd), .crtc_dat_rd(crtc_dat_rd), .crtc_wdata(crtc_wdata),
    .attr_ff_clr(attr_ff_clr), .color_mode(color_mode), .clk_sel(clk_sel),
    .hi_bank(hi_bank), .hsync_neg(hsync_neg), .vsync_neg(vsync_neg), .line_code(line_code)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] m_byte;
  logic       m_clr;

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic [15:0] a, logic w, logic r, logic [7:0] wd,
                      logic v, logic h, logic [7:0] crd);
    logic [15:0] base;
    logic [7:0]  er;
    @(negedge clk);
    io_addr = a; io_wr = w; io_rd = r; io_wdata = wd;
    vretrace = v; hretrace = h; crtc_rdata = crd;
    #1;
    base = m_byte[0] ? 16'h03D0 : 16'h03B0;
    if (!r)                                       er = 8'hFF;
    else if (a == 16'h03CC)                       er = m_byte;
    else if (a == base + 4 || a == base + 5)      er = crd;
    else if (a == base + 16'h000A)                er = {4'b0, v, 2'b0, v | h};
    else                                          er = 8'hFF;
    chk(tag, "io_rdata", io_rdata, er);
    chk(tag, "crtc_idx_wr", crtc_idx_wr, w && a == base + 4);
    chk(tag, "crtc_dat_wr", crtc_dat_wr, w && a == base + 5);
    chk(tag, "crtc_idx_rd", crtc_idx_rd, r && a == base + 4);
    chk(tag, "crtc_dat_rd", crtc_dat_rd, r && a == base + 5);
    chk(tag, "crtc_wdata", crtc_wdata, wd);
    chk(tag, "attr_ff_clr", attr_ff_clr, m_clr);
    chk(tag, "color_mode", color_mode, m_byte[0]);
    chk(tag, "clk_sel", clk_sel, m_byte[3:2]);
    chk(tag, "hi_bank", hi_bank, m_byte[5]);
    chk(tag, "hsync_neg", hsync_neg, m_byte[6]);
    chk(tag, "vsync_neg", vsync_neg, m_byte[7]);
    chk(tag, "line_code", line_code, m_byte[7:6]);
    @(posedge clk);
    m_clr = r && (a == base + 16'h000A);
    if (w && a == 16'h03C2) m_byte = wd;
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; io_addr = 16'h03C2; io_wr = 1'b1; io_rd = 1'b0;
    io_wdata = 8'hFF; vretrace = 1'b0; hretrace = 1'b0; crtc_rdata = 8'h00;
    m_byte = 8'h00; m_clr = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1: write during reset is held off
    chk("R1", "color_mode", color_mode, 1'b0);
    chk("R1", "line_code", line_code, 2'b00);
    chk("R1", "attr_ff_clr", attr_ff_clr, 1'b0);
    @(negedge clk);
    io_wr = 1'b0;
    rst_n = 1'b1;
    step("R1", 16'h03CC, 0, 1, 8'h00, 0, 0, 8'h00);
    // R4 mono CRTC ports, R11 forwarding
    step("R4", 16'h03B4, 0, 1, 8'h00, 0, 0, 8'h5A);
    step("R11", 16'h03B5, 1, 0, 8'h3C, 0, 0, 8'h00);
    step("R11", 16'h03B4, 1, 0, 8'h11, 0, 0, 8'h00);
    step("R4", 16'h03D4, 0, 1, 8'h00, 0, 0, 8'h77);
    step("R4", 16'h03D5, 1, 0, 8'h99, 0, 0, 8'h00);
    // R5/R6/R7 mono status
    step("R6", 16'h03BA, 0, 1, 8'h00, 0, 1, 8'h00);
    step("R7", 16'h03BA, 0, 1, 8'h00, 1, 0, 8'h00);
    step("R7", 16'h03BA, 0, 1, 8'h00, 1, 1, 8'h00);
    step("R7", 16'h0000, 0, 0, 8'h00, 0, 0, 8'h00);
    step("R5", 16'h03DA, 0, 1, 8'h00, 1, 1, 8'h00);
    step("R5", 16'h0000, 0, 0, 8'h00, 0, 0, 8'h00);
    // R2/R10 switch to colour, access right after the write
    step("R2", 16'h03C2, 1, 0, 8'h01, 0, 0, 8'h00);
    step("R10", 16'h03D4, 0, 1, 8'h00, 0, 0, 8'hA5);
    step("R3", 16'h03B4, 0, 1, 8'h00, 0, 0, 8'hA5);
    step("R3", 16'h03B5, 1, 0, 8'h42, 0, 0, 8'h00);
    step("R3", 16'h03D5, 0, 1, 8'h00, 0, 0, 8'hC3);
    step("R5", 16'h03BA, 0, 1, 8'h00, 1, 0, 8'h00);
    step("R6", 16'h03DA, 0, 1, 8'h00, 0, 0, 8'h00);
    step("R6", 16'h03DA, 0, 1, 8'h00, 1, 0, 8'h00);
    step("R7", 16'h03DA, 0, 0, 8'h00, 1, 0, 8'h00);
    // R8 field patterns
    step("R8", 16'h03C2, 1, 0, 8'hEF, 0, 0, 8'h00);
    step("R8", 16'h03CC, 0, 1, 8'h00, 0, 0, 8'h00);
    step("R8", 16'h03C2, 1, 0, 8'h45, 0, 0, 8'h00);
    step("R8", 16'h03C2, 1, 0, 8'hA9, 0, 0, 8'h00);
    step("R8", 16'h03CC, 0, 1, 8'h00, 0, 0, 8'h00);
    // R9 undecoded accesses
    step("R9", 16'h03CC, 1, 0, 8'h00, 0, 0, 8'h00);
    step("R9", 16'h03CC, 0, 1, 8'h00, 0, 0, 8'h00);
    step("R9", 16'h03C2, 0, 1, 8'h00, 0, 0, 8'h00);
    step("R9", 16'h13C2, 1, 0, 8'h00, 0, 0, 8'h00);
    step("R9", 16'h03CC, 0, 1, 8'h00, 0, 0, 8'h00);
    step("R9", 16'h03D4, 0, 0, 8'h00, 0, 0, 8'h12);
    // R10 back to mono, access right after the write
    step("R10", 16'h03C2, 1, 0, 8'h00, 0, 0, 8'h00);
    step("R10", 16'h03B4, 0, 1, 8'h00, 0, 0, 8'h6E);
    step("R10", 16'h03BA, 0, 1, 8'h00, 0, 1, 8'h00);
    step("R7", 16'h0000, 0, 0, 8'h00, 0, 0, 8'h00);
    step("R7", 16'h0000, 0, 0, 8'h00, 0, 0, 8'h00);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule